// File: doc/BRIEF.md
# HDLC Receive Deframer with Address Filter

This block takes a serial line, one bit per cycle in which `bit_valid` is high, and turns HDLC framing into a stream of receive-FIFO writes. It counts runs of ones to tell flags, aborts and an idle line apart. Each flag resets its byte boundary. Inside a frame it removes the zero that the sender inserts after five ones. It runs a 16-bit frame check sequence over every whole byte.

Only packet data reaches the FIFO interface. Flags, abort runs and the two check bytes never do. The last two bytes of a frame are held back until the closing flag shows that they were the check sequence. The last data byte then carries an end-of-packet tag and a pass/fail mark for the check sequence. An abort writes the oldest held byte with an abort tag. An optional filter compares the first byte of each frame against a programmed address and the all-call value 0xFF, and drops the whole frame when neither matches.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset, and whenever `rx_en` is low, the block ignores the line. It writes nothing to the FIFO and holds `idle_o` low. With `addr_en` low, a frame is accepted whatever its first byte is.
- R2: While enabled, `idle_o` rises on the 15th consecutive valid one and falls on the next valid zero. It stays low after only 14 ones.
- R3: A flag (a zero, six ones, a zero) resets the byte boundary, so stray bits between two flags do not shift the bytes of the frame that follows.
- R4: Inside a frame, a zero that follows five consecutive ones is removed and is not part of the data.
- R5: A frame of n whole bytes between flags, with n of at least 3, gives exactly n-2 FIFO writes in arrival order, so the check bytes never reach the FIFO. A frame of fewer than 3 bytes gives no write.
- R6: The last write of a closed frame has `fifo_eop` high. `fifo_fcs_ok` is high only when the 16-bit check over all bytes (reflected polynomial 0x8408, preset 0xFFFF, bits least significant first) leaves the residue 0xF0B8 and the frame ended on a byte boundary. Earlier writes carry no tags.
- R7: With `addr_en` high, a frame whose first byte equals `addr_value` or 0xFF is delivered in full, address byte included.
- R8: With `addr_en` high, a frame whose first byte matches neither address gives no FIFO write, including at its close or on an abort.
- R9: Seven consecutive ones inside a frame abort it. If any byte is held, the oldest held byte is written with `fifo_abort` and `fifo_eop` high and `fifo_fcs_ok` low. Nothing more is written until the next flag.
- R10: A single flag can close one frame and open the next. Both frames are delivered correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| addr_en | input | 1 | Address filter enable |
| addr_value | input | 8 | Programmed station address |
| bit_in | input | 1 | Serial line bit |
| bit_valid | input | 1 | Marks a cycle that carries a new line bit |
| idle_o | output | 1 | Idle-channel status |
| fifo_wr | output | 1 | One-cycle write strobe to the receive FIFO |
| fifo_data | output | 8 | Data byte for the FIFO |
| fifo_eop | output | 1 | Entry is the last of its packet |
| fifo_fcs_ok | output | 1 | Check sequence passed (valid with eop) |
| fifo_abort | output | 1 | Packet was aborted (valid with eop) |

## Verification
The flag detector serves two purposes in one event: the same flag cycle both closes a frame and opens the next one. In that cycle the end-of-packet write of the first frame must come out, and the check register, byte counter and hold buffer must be preset for the second. The bench provokes this by sending two frames back to back with one shared flag. The check passes only if the first frame ends with a good tag and the second frame arrives intact with its own good tag. A second pair is the stray bits before a realigning flag: they can complete a junk byte in the same bit window that the flag arrives. The bench judges that case by the next frame being delivered correctly.

// File: rtl/hdlc_rx_pkg.sv
// Shared constants and the byte-wise check-sequence update for the HDLC receiver.
// Assumes 8-bit bytes sent least significant bit first.
package hdlc_rx_pkg;
    localparam int          BYTE_W      = 8;
    localparam int          FLAG_LEAD   = 6;        // bits of a flag pushed before its sixth one
    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_GOOD    = 16'hF0B8;
    localparam logic [15:0] CRC_POLY    = 16'h8408;
    localparam logic [7:0]  ALL_CALL    = 8'hFF;

    // Advance the reflected 16-bit check by one byte, LSB first.
    function automatic logic [15:0] crc_byte(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c;
        c = c_in;
        for (int i = 0; i < BYTE_W; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY;
            else             c = c >> 1;
        end
        return c;
    endfunction
endpackage

// File: rtl/hdlc_rx_bitproc.sv
// Line-level run-of-ones tracker. Classifies every valid bit as data, a
// stuffed zero, a flag end, an abort or nothing. Keeps the idle status.
// Assumes IDLE_ONES >= 8. Events are combinational from the current bit.
module hdlc_rx_bitproc #(
    parameter int IDLE_ONES = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic bit_in,
    input  logic bit_valid,
    output logic data_stb,
    output logic data_bit,
    output logic flag_stb,
    output logic abort_stb,
    output logic idle
);
    localparam int OW = $clog2(IDLE_ONES + 1);
    localparam logic [OW-1:0] FIVE    = OW'(5);
    localparam logic [OW-1:0] SIX     = OW'(6);
    localparam logic [OW-1:0] IDLE_M1 = OW'(IDLE_ONES - 1);
    localparam logic [OW-1:0] SAT     = OW'(IDLE_ONES);

    logic [OW-1:0] ones;
    logic          live;

    // Classify the incoming bit against the run of ones seen so far.
    always_comb begin
        live      = rx_en && bit_valid;
        data_stb  = live && (ones < FIVE);
        data_bit  = bit_in;
        flag_stb  = live && !bit_in && (ones == SIX);
        abort_stb = live &&  bit_in && (ones == SIX);
    end

    // Count consecutive ones (saturating) and track the idle line.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            ones <= '0;
            idle <= 1'b0;
        end else if (bit_valid) begin
            if (bit_in) begin
                if (ones != SAT) ones <= ones + OW'(1);
                if (ones == IDLE_M1) idle <= 1'b1;
            end else begin
                ones <= '0;
                idle <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_framer.sv
// Byte assembler, check-sequence accumulator, address filter and hold-back
// buffer. Acts on events from the bit tracker. Holds FCS_BYTES+1 bytes so that
// the check bytes are never written and the last data byte can carry the
// end-of-packet tags. Produces at most one FIFO write per cycle.
module hdlc_rx_framer
    import hdlc_rx_pkg::*;
#(
    parameter int FCS_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              addr_en,
    input  logic [BYTE_W-1:0] addr_value,
    input  logic              data_stb,
    input  logic              data_bit,
    input  logic              flag_stb,
    input  logic              abort_stb,
    output logic              fifo_wr,
    output logic [BYTE_W-1:0] fifo_data,
    output logic              fifo_eop,
    output logic              fifo_fcs_ok,
    output logic              fifo_abort
);
    localparam int HOLD = FCS_BYTES + 1;
    localparam int HCW  = $clog2(HOLD + 1);
    localparam int NBW  = $clog2(BYTE_W);
    localparam logic [HCW-1:0] HOLD_FULL = HCW'(HOLD);
    localparam logic [NBW-1:0] LAST_BIT  = NBW'(BYTE_W - 1);
    localparam logic [NBW-1:0] LEAD_BITS = NBW'(FLAG_LEAD);

    logic              synced, in_frame, drop;
    logic [NBW-1:0]    nbits;
    logic [BYTE_W-1:0] acc;
    logic [15:0]       crc;
    logic [HCW-1:0]    hcnt;
    logic [BYTE_W-1:0] hold [HOLD];
    logic [BYTE_W-1:0] byte_next;
    logic              addr_miss;

    // Next byte value and address comparison for the byte now completing.
    always_comb begin
        byte_next = {data_bit, acc[BYTE_W-1:1]};
        addr_miss = addr_en && (byte_next != addr_value) && (byte_next != ALL_CALL);
    end

    // Frame state machine: realign on flags, drop on abort, assemble and hold bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            synced      <= 1'b0;
            in_frame    <= 1'b0;
            drop        <= 1'b0;
            nbits       <= '0;
            acc         <= '0;
            crc         <= CRC_PRESET;
            hcnt        <= '0;
            fifo_wr     <= 1'b0;
            fifo_data   <= '0;
            fifo_eop    <= 1'b0;
            fifo_fcs_ok <= 1'b0;
            fifo_abort  <= 1'b0;
            for (int i = 0; i < HOLD; i++) hold[i] <= '0;
        end else begin
            fifo_wr     <= 1'b0;
            fifo_eop    <= 1'b0;
            fifo_fcs_ok <= 1'b0;
            fifo_abort  <= 1'b0;
            if (flag_stb) begin
                if (in_frame && !drop && hcnt == HOLD_FULL) begin
                    fifo_wr     <= 1'b1;
                    fifo_data   <= hold[0];
                    fifo_eop    <= 1'b1;
                    fifo_fcs_ok <= (crc == CRC_GOOD) && (nbits == LEAD_BITS);
                end
                synced   <= 1'b1;
                in_frame <= 1'b0;
                drop     <= 1'b0;
                nbits    <= '0;
                crc      <= CRC_PRESET;
                hcnt     <= '0;
            end else if (abort_stb) begin
                if (in_frame && !drop && hcnt != '0) begin
                    fifo_wr    <= 1'b1;
                    fifo_data  <= hold[0];
                    fifo_eop   <= 1'b1;
                    fifo_abort <= 1'b1;
                end
                synced   <= 1'b0;
                in_frame <= 1'b0;
            end else if (data_stb && synced) begin
                acc <= byte_next;
                if (nbits == LAST_BIT) begin
                    nbits    <= '0;
                    crc      <= crc_byte(crc, byte_next);
                    in_frame <= 1'b1;
                    if (!in_frame && addr_miss) begin
                        drop <= 1'b1;
                    end else if (!drop) begin
                        if (hcnt == HOLD_FULL) begin
                            fifo_wr   <= 1'b1;
                            fifo_data <= hold[0];
                            for (int i = 0; i < HOLD - 1; i++) hold[i] <= hold[i+1];
                            hold[HOLD-1] <= byte_next;
                        end else begin
                            for (int i = 0; i < HOLD; i++)
                                if (HCW'(i) == hcnt) hold[i] <= byte_next;
                            hcnt <= hcnt + HCW'(1);
                        end
                    end
                end else begin
                    nbits <= nbits + NBW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_deframer.sv
// Top of the HDLC receive deframer: bit tracker followed by the framer.
// Assumes one line bit per cycle with bit_valid high; FIFO writes are never refused.
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int IDLE_ONES = 15,
    parameter int FCS_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              addr_en,
    input  logic [BYTE_W-1:0] addr_value,
    input  logic              bit_in,
    input  logic              bit_valid,
    output logic              idle_o,
    output logic              fifo_wr,
    output logic [BYTE_W-1:0] fifo_data,
    output logic              fifo_eop,
    output logic              fifo_fcs_ok,
    output logic              fifo_abort
);
    logic data_stb, data_bit, flag_stb, abort_stb;

    hdlc_rx_bitproc #(.IDLE_ONES(IDLE_ONES)) u_bits (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
        .bit_in(bit_in), .bit_valid(bit_valid),
        .data_stb(data_stb), .data_bit(data_bit),
        .flag_stb(flag_stb), .abort_stb(abort_stb), .idle(idle_o)
    );

    hdlc_rx_framer #(.FCS_BYTES(FCS_BYTES)) u_frame (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
        .addr_en(addr_en), .addr_value(addr_value),
        .data_stb(data_stb), .data_bit(data_bit),
        .flag_stb(flag_stb), .abort_stb(abort_stb),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_eop(fifo_eop),
        .fifo_fcs_ok(fifo_fcs_ok), .fifo_abort(fifo_abort)
    );
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
// Port-level properties of the deframer, bound to every instance of the top.
module hdlc_rx_deframer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       bit_in,
    input logic       bit_valid,
    input logic       idle_o,
    input logic       fifo_wr,
    input logic       fifo_eop,
    input logic       fifo_fcs_ok,
    input logic       fifo_abort
);
    // R1
    rx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!fifo_wr && !idle_o));

    // R2
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && bit_valid && !bit_in) |=> !idle_o);

    // R2
    idle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_o) |-> $past(rx_en && bit_valid && bit_in));

    // R6
    tag_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_eop || fifo_fcs_ok || fifo_abort) |-> fifo_wr);

    // R9
    abort_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_abort |-> (fifo_eop && !fifo_fcs_ok));

    // R6
    fcs_ok_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_fcs_ok |-> fifo_eop);
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_in(bit_in),
    .bit_valid(bit_valid), .idle_o(idle_o), .fifo_wr(fifo_wr),
    .fifo_eop(fifo_eop), .fifo_fcs_ok(fifo_fcs_ok), .fifo_abort(fifo_abort)
);

// File: tb/hdlc_rx_deframer_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checks its own captured FIFO writes.
module hdlc_rx_deframer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       addr_en = 1'b0;
    logic [7:0] addr_value = 8'h00;
    logic       bit_in = 1'b0;
    logic       bit_valid = 1'b0;
    logic       idle_o, fifo_wr, fifo_eop, fifo_fcs_ok, fifo_abort;
    logic [7:0] fifo_data;

    int errs = 0;
    int checks = 0;
    int ones_run = 0;

    logic [7:0] pkt [16];
    int         pkt_n = 0;

    logic [7:0] cap_d [32];
    logic       cap_e [32];
    logic       cap_k [32];
    logic       cap_a [32];
    int         cap_n = 0;

    always #2.5 clk = ~clk;

    hdlc_rx_deframer u_hdlc_rx_deframer (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .addr_en(addr_en),
        .addr_value(addr_value), .bit_in(bit_in), .bit_valid(bit_valid),
        .idle_o(idle_o), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
        .fifo_eop(fifo_eop), .fifo_fcs_ok(fifo_fcs_ok), .fifo_abort(fifo_abort)
    );

    // Record every FIFO write, sampled away from the active edge.
    always @(negedge clk) begin
        if (fifo_wr && cap_n < 32) begin
            cap_d[cap_n] = fifo_data;
            cap_e[cap_n] = fifo_eop;
            cap_k[cap_n] = fifo_fcs_ok;
            cap_a[cap_n] = fifo_abort;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One line bit, valid for one cycle, followed by a gap cycle.
    task automatic send_raw(input logic b);
        @(negedge clk);
        bit_in = b;
        bit_valid = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic send_flag();
        send_raw(1'b0);
        for (int i = 0; i < 6; i++) send_raw(1'b1);
        send_raw(1'b0);
        ones_run = 0;
    endtask

    // Data bit with zero insertion after five ones.
    task automatic send_dbit(input logic b);
        send_raw(b);
        if (b) begin
            ones_run++;
            if (ones_run == 5) begin
                send_raw(1'b0);
                ones_run = 0;
            end
        end else ones_run = 0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_dbit(v[i]);
    endtask

    // Frame body: pkt bytes then the complemented check, low byte first.
    task automatic send_body(input bit corrupt);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int j = 0; j < pkt_n; j++)
            for (int k = 0; k < 8; k++)
                c = ((c[0] ^ pkt[j][k]) != 1'b0) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        c = ~c;
        if (corrupt) c[3] = ~c[3];
        for (int j = 0; j < pkt_n; j++) send_byte(pkt[j]);
        send_byte(c[7:0]);
        send_byte(c[15:8]);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Compare captured entries against pkt starting at index base.
    task automatic expect_frame(input string req, input int base, input int n, input bit ok);
        for (int i = 0; i < n; i++) begin
            chk({req, " data"}, int'(cap_d[base+i]), int'(pkt[i]));
            chk({req, " eop"},  int'(cap_e[base+i]), (i == n - 1) ? 1 : 0);
            chk({req, " fcs"},  int'(cap_k[base+i]), (i == n - 1 && ok) ? 1 : 0);
            chk({req, " abort"}, int'(cap_a[base+i]), 0);
        end
    endtask

    task automatic set_pkt4(input logic [7:0] a, input logic [7:0] b,
                            input logic [7:0] c, input logic [7:0] d, input int n);
        pkt[0] = a; pkt[1] = b; pkt[2] = c; pkt[3] = d; pkt_n = n;
    endtask

    task automatic t_reset();
        chk("R1 idle after reset", int'(idle_o), 0);
        chk("R1 no write after reset", int'(fifo_wr), 0);
        set_pkt4(8'h12, 8'h34, 8'h56, 8'h00, 3);
        send_flag(); send_body(1'b0); send_flag();
        for (int i = 0; i < 20; i++) send_raw(1'b1);
        settle();
        chk("R1 disabled writes", cap_n, 0);
        chk("R1 disabled idle", int'(idle_o), 0);
    endtask

    task automatic t_good();
        cap_n = 0;
        set_pkt4(8'h7E, 8'hFF, 8'h3E, 8'hF8, 4);
        send_flag(); send_body(1'b0); send_flag();
        settle();
        chk("R5 count good frame", cap_n, 4);
        expect_frame("R4 R6 good frame", 0, 4, 1'b1);
    endtask

    task automatic t_badfcs();
        cap_n = 0;
        set_pkt4(8'h12, 8'h34, 8'h00, 8'h00, 2);
        send_flag(); send_body(1'b1); send_flag();
        settle();
        chk("R6 count bad frame", cap_n, 2);
        expect_frame("R6 bad fcs", 0, 2, 1'b0);
    endtask

    task automatic t_short();
        cap_n = 0;
        send_flag(); send_byte(8'hAA); send_byte(8'h55); send_flag();
        settle();
        chk("R5 short frame", cap_n, 0);
    endtask

    task automatic t_addr();
        addr_en = 1'b1;
        addr_value = 8'h5A;
        cap_n = 0;
        set_pkt4(8'h5A, 8'h01, 8'h02, 8'h00, 3);
        send_flag(); send_body(1'b0); send_flag();
        settle();
        chk("R7 own address count", cap_n, 3);
        expect_frame("R7 own address", 0, 3, 1'b1);
        cap_n = 0;
        set_pkt4(8'hFF, 8'h09, 8'h00, 8'h00, 2);
        send_flag(); send_body(1'b0); send_flag();
        settle();
        chk("R7 all-call count", cap_n, 2);
        expect_frame("R7 all-call", 0, 2, 1'b1);
        cap_n = 0;
        set_pkt4(8'h33, 8'h44, 8'h55, 8'h66, 4);
        send_flag(); send_body(1'b0); send_flag();
        settle();
        chk("R8 mismatch dropped", cap_n, 0);
        cap_n = 0;
        send_flag(); send_byte(8'h33); send_byte(8'h44); send_byte(8'h55); send_byte(8'h66);
        for (int i = 0; i < 7; i++) send_raw(1'b1);
        send_flag();
        settle();
        chk("R8 mismatch abort dropped", cap_n, 0);
        addr_en = 1'b0;
    endtask

    task automatic t_abort();
        cap_n = 0;
        send_flag();
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44); send_byte(8'h55);
        for (int i = 0; i < 7; i++) send_raw(1'b1);
        send_raw(1'b0); send_raw(1'b1); send_raw(1'b0);
        settle();
        chk("R9 abort count", cap_n, 3);
        chk("R9 abort data", int'(cap_d[2]), 8'h33);
        chk("R9 abort tag", int'(cap_a[2]), 1);
        chk("R9 abort eop", int'(cap_e[2]), 1);
        chk("R9 abort fcs", int'(cap_k[2]), 0);
        chk("R9 before abort", int'(cap_a[1]), 0);
        send_flag();
    endtask

    task automatic t_idle();
        send_flag();
        for (int i = 0; i < 14; i++) send_raw(1'b1);
        chk("R2 fourteen ones", int'(idle_o), 0);
        send_raw(1'b1);
        chk("R2 fifteen ones", int'(idle_o), 1);
        send_raw(1'b1);
        chk("R2 held idle", int'(idle_o), 1);
        send_raw(1'b0);
        chk("R2 zero clears idle", int'(idle_o), 0);
    endtask

    task automatic t_realign();
        cap_n = 0;
        send_flag();
        send_raw(1'b0); send_raw(1'b1); send_raw(1'b0);
        send_flag();
        set_pkt4(8'hA5, 8'h5A, 8'hC3, 8'h00, 3);
        send_body(1'b0); send_flag();
        settle();
        chk("R3 realign count", cap_n, 3);
        expect_frame("R3 realign", 0, 3, 1'b1);
    endtask

    task automatic t_shared();
        cap_n = 0;
        set_pkt4(8'h01, 8'h80, 8'h00, 8'h00, 2);
        send_flag(); send_body(1'b0); send_flag();
        set_pkt4(8'hFE, 8'h7F, 8'h10, 8'h00, 3);
        send_body(1'b0); send_flag();
        settle();
        chk("R10 shared flag count", cap_n, 5);
        chk("R10 first eop", int'(cap_e[1]), 1);
        chk("R10 first fcs", int'(cap_k[1]), 1);
        chk("R10 first data", int'(cap_d[0]), 8'h01);
        expect_frame("R10 second frame", 2, 3, 1'b1);
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        rx_en = 1'b1;
        t_good();
        t_badfcs();
        t_short();
        t_addr();
        t_abort();
        t_idle();
        t_realign();
        t_shared();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule